// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits between the bus-side write latch of a byte-wide nonvolatile memory and its write controller. Every latched write (address and data) passes through it as a stream beat, and each beat comes out one cycle later with a commit bit. The controller programs the byte into the array only when that bit is set. The detector looks for two fixed command patterns in the stream. The short lock pattern turns write protection on. The long unlock pattern turns it off. Command bytes are never committed.

While protection is on, ordinary writes are dropped. There is one exception: data bytes that follow a completed lock pattern inside the same page load are still committed. A partial pattern is abandoned when a byte breaks it or when the page load ends, which the page-load timer signals on `load_done`.

The protect flag models a nonvolatile bit. Only the power-on reset `por_n` clears it, so the device starts unprotected. The warm reset `rst_n` clears the matcher and the output stage but leaves the flag untouched.

The input and output both use valid/ready. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever `rst_n` is high and the output register is either empty or being drained in that cycle. A beat held on the output (`out_valid` high, `out_ready` low) keeps its address, data and commit bit stable until it is taken. Beats leave in the same order they arrived, one beat out for each beat in.

Top module: `wp_seq_detect`

## Requirements
- R1: While `por_n` is low, on the next clock `prot_on` is 0 and `out_valid` is 0.
- R2: While `rst_n` is low, `out_valid` goes to 0, no input is accepted and `prot_on` keeps its value.
- R3: The accepted bytes 0xAA at 0x1555, then 0x55 at 0x0AAA, then 0xA0 at 0x1555 set `prot_on`, and none of the three is committed.
- R4: The accepted bytes 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 clear `prot_on`, and none of the six is committed. The first two bytes are shared with the lock pattern, so both patterns stay live until the third byte.
- R5: Only address bits 12..0 are compared with the command addresses. Higher bits may differ from byte to byte.
- R6: While `prot_on` is 0, every byte that is not part of a command pattern leaves with `out_commit`=1.
- R7: While `prot_on` is 1, an ordinary byte leaves with `out_commit`=0 unless R8 applies.
- R8: After a lock pattern completes, ordinary bytes in the same page load are committed while `prot_on` stays 1. A `load_done` pulse ends this window.
- R9: A byte that breaks a partial pattern returns the matcher to idle and is handled as an ordinary byte (R6/R7). The matcher does not treat it as the start of a new pattern.
- R10: A `load_done` pulse discards a partial pattern, so the remaining bytes of that pattern are then ordinary writes.
- R11: Each accepted beat appears on the output on the next clock with the same address and data. A stalled output beat stays stable until `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including the protect flag |
| rst_n | input | 1 | Warm reset, active low, keeps the protect flag |
| in_valid | input | 1 | Latched write beat is present |
| in_ready | output | 1 | Detector can take a beat |
| in_addr | input | AW | Write address |
| in_data | input | 8 | Write data |
| load_done | input | 1 | One-cycle pulse: the page-load window has closed |
| out_valid | output | 1 | Decided beat is present |
| out_ready | input | 1 | Write controller takes the beat |
| out_addr | output | AW | Address of the decided beat |
| out_data | output | 8 | Data of the decided beat |
| out_commit | output | 1 | 1: program this byte; 0: drop it |
| prot_on | output | 1 | Write protection is active |

## Verification
The assertions assume that `por_n` is held low for at least two clocks before it is first released. They also assume that `load_done` never coincides with an accepted beat, because in that case the pulse overrides the matcher update. The bench drives `load_done` only in cycles where `in_valid` is low. It drives all inputs at the falling edge, keeps `out_ready` high except during the back-pressure scenario, and ends power-on reset only after several clocks.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int CMD_AW = 13;
  localparam int DATA_W = 8;
  localparam logic [CMD_AW-1:0] ADR_A = 13'h1555;
  localparam logic [CMD_AW-1:0] ADR_B = 13'h0AAA;
  localparam logic [DATA_W-1:0] KEY_1 = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_2 = 8'h55;
  localparam logic [DATA_W-1:0] OP_LOCK = 8'hA0;
  localparam logic [DATA_W-1:0] OP_PRE = 8'h80;
  localparam logic [DATA_W-1:0] OP_UNLOCK = 8'h20;

  // progress through the shared prefix and the unlock tail
  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_PRE, ST_PRE_K1, ST_PRE_K2
  } step_t;
endpackage

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
  import wp_pkg::*;
(
  input  step_t               cur,
  input  logic [CMD_AW-1:0]   addr,
  input  logic [DATA_W-1:0]   data,
  output step_t               nxt,
  output logic                is_cmd,
  output logic                do_lock,
  output logic                do_unlock
);
  logic at_a, at_b;
  assign at_a = (addr == ADR_A);
  assign at_b = (addr == ADR_B);

  always_comb begin
    nxt = ST_IDLE;
    is_cmd = 1'b0;
    do_lock = 1'b0;
    do_unlock = 1'b0;
    unique case (cur)
      ST_IDLE: if (at_a && data == KEY_1) begin nxt = ST_K1; is_cmd = 1'b1; end
      ST_K1:   if (at_b && data == KEY_2) begin nxt = ST_K2; is_cmd = 1'b1; end
      ST_K2: begin
        if (at_a && data == OP_LOCK) begin
          is_cmd = 1'b1;
          do_lock = 1'b1;
        end else if (at_a && data == OP_PRE) begin
          nxt = ST_PRE;
          is_cmd = 1'b1;
        end
      end
      ST_PRE:    if (at_a && data == KEY_1) begin nxt = ST_PRE_K1; is_cmd = 1'b1; end
      ST_PRE_K1: if (at_b && data == KEY_2) begin nxt = ST_PRE_K2; is_cmd = 1'b1; end
      ST_PRE_K2: if (at_a && data == OP_UNLOCK) begin is_cmd = 1'b1; do_unlock = 1'b1; end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wp_mode_regs.sv
module wp_mode_regs
  import wp_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  load_done,
  input  step_t nxt,
  input  logic  do_lock,
  input  logic  do_unlock,
  output step_t cur,
  output logic  prot,
  output logic  armed
);
  // nonvolatile flag: only power-on clears it
  always_ff @(posedge clk) begin
    if (!por_n) prot <= 1'b0;
    else if (adv && do_lock) prot <= 1'b1;
    else if (adv && do_unlock) prot <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n || load_done) begin
      cur <= ST_IDLE;
      armed <= 1'b0;
    end else if (adv) begin
      cur <= nxt;
      if (do_lock) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/wp_out_stage.sv
module wp_out_stage #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          commit_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          commit_o
);
  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      valid_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      commit_o <= 1'b0;
    end else if (take) begin
      valid_o <= 1'b1;
      addr_o <= addr_i;
      data_o <= data_i;
      commit_o <= commit_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
  import wp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              load_done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_commit,
  output logic              prot_on
);
  localparam int PAD = (AW >= CMD_AW) ? 0 : CMD_AW - AW;

  logic [CMD_AW-1:0] cmp_addr;
  step_t cur, nxt;
  logic is_cmd, do_lock, do_unlock, armed, adv, commit;

  generate
    if (AW >= CMD_AW) begin : g_slice
      assign cmp_addr = in_addr[CMD_AW-1:0];
    end else begin : g_pad
      assign cmp_addr = {{PAD{1'b0}}, in_addr};
    end
  endgenerate

  assign in_ready = rst_n && (!out_valid || out_ready);
  assign adv = in_valid && in_ready;
  assign commit = !is_cmd && (!prot_on || armed);

  wp_cmd_match u_match (
    .cur(cur), .addr(cmp_addr), .data(in_data),
    .nxt(nxt), .is_cmd(is_cmd), .do_lock(do_lock), .do_unlock(do_unlock)
  );

  wp_mode_regs u_mode (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .adv(adv), .load_done(load_done),
    .nxt(nxt), .do_lock(do_lock), .do_unlock(do_unlock),
    .cur(cur), .prot(prot_on), .armed(armed)
  );

  wp_out_stage #(.AW(AW), .DW(DATA_W)) u_out (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .take(adv),
    .addr_i(in_addr), .data_i(in_data), .commit_i(commit), .ready_i(out_ready),
    .valid_o(out_valid), .addr_o(out_addr), .data_o(out_data), .commit_o(out_commit)
  );
endmodule

// File: rtl/wp_seq_detect_chk.sv
module wp_seq_detect_chk
  import wp_pkg::*;
#(
  parameter int AW = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [AW-1:0]     in_addr,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [AW-1:0]     out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic              out_commit,
  input logic              prot_on
);
  // R1
  por_clear_chk: assert property (@(posedge clk)
    !por_n |=> !prot_on && !out_valid);

  // R2
  warm_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> prot_on == $past(prot_on) && !out_valid);

  // R3
  lock_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) && $rose(prot_on) |-> out_valid && !out_commit && out_data == OP_LOCK);

  // R4
  unlock_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) && $fell(prot_on) |-> out_valid && !out_commit && out_data == OP_UNLOCK);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_commit));

  // R11
  accept_fwd_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    in_valid && in_ready |=> out_valid && out_addr == $past(in_addr) && out_data == $past(in_data));
endmodule

bind wp_seq_detect wp_seq_detect_chk #(.AW(AW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_data(out_data), .out_commit(out_commit), .prot_on(prot_on)
);

// File: tb/wp_seq_detect_bench.sv
`timescale 1ns/1ps
module wp_seq_detect_bench;
  localparam int AW = 16;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, load_done = 1'b0, out_ready = 1'b1;
  logic [AW-1:0] in_addr = '0, out_addr;
  logic [7:0] in_data = '0, out_data;
  logic out_valid, out_commit, prot_on;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wp_seq_detect #(.AW(AW)) u_wp_seq_detect (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .load_done(load_done), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
    .out_commit(out_commit), .prot_on(prot_on)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one beat through with out_ready high; checks the decided beat
  task automatic send(input string req, input logic [AW-1:0] a, input logic [7:0] d,
                      input logic exp_commit, input logic exp_prot);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, "out_addr", int'(out_addr), int'(a));
    chk(req, "out_commit", int'(out_commit), int'(exp_commit));
    chk(req, "prot_on", int'(prot_on), int'(exp_prot));
  endtask

  task automatic end_load();
    @(negedge clk); load_done = 1'b1;
    @(negedge clk); load_done = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "prot after por", int'(prot_on), 0);
    chk("R1", "valid after por", int'(out_valid), 0);
  endtask

  task automatic t_plain();
    send("R6", 16'h0040, 8'h3C, 1'b1, 1'b0);
    send("R6", 16'h1555, 8'h55, 1'b1, 1'b0);
  endtask

  task automatic t_lock();
    // R5: upper bits differ per byte
    send("R3", 16'h1555, 8'hAA, 1'b0, 1'b0);
    send("R5", 16'h2AAA, 8'h55, 1'b0, 1'b0);
    send("R3", 16'hF555, 8'hA0, 1'b0, 1'b1);
    send("R8", 16'h0123, 8'h9E, 1'b1, 1'b1);
    send("R8", 16'h0124, 8'h9F, 1'b1, 1'b1);
    end_load();
    send("R7", 16'h0123, 8'h11, 1'b0, 1'b1);
  endtask

  task automatic t_abort_prot();
    send("R9", 16'h1555, 8'hAA, 1'b0, 1'b1);
    send("R9", 16'h0AAA, 8'h12, 1'b0, 1'b1);
    end_load();
  endtask

  task automatic t_warm();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R2", "in_ready in warm reset", int'(in_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    chk("R2", "prot kept", int'(prot_on), 1);
    chk("R2", "valid cleared", int'(out_valid), 0);
  endtask

  task automatic t_unlock();
    send("R4", 16'h1555, 8'hAA, 1'b0, 1'b1);
    send("R4", 16'h0AAA, 8'h55, 1'b0, 1'b1);
    send("R4", 16'h1555, 8'h80, 1'b0, 1'b1);
    send("R4", 16'h1555, 8'hAA, 1'b0, 1'b1);
    send("R4", 16'h4AAA, 8'h55, 1'b0, 1'b1);
    send("R4", 16'h1555, 8'h20, 1'b0, 1'b0);
    send("R6", 16'h0200, 8'h77, 1'b1, 1'b0);
    end_load();
  endtask

  task automatic t_abort_unprot();
    send("R9", 16'h1555, 8'hAA, 1'b0, 1'b0);
    send("R9", 16'h0AAA, 8'h55, 1'b0, 1'b0);
    send("R9", 16'h1555, 8'h77, 1'b1, 1'b0);
    send("R9", 16'h1555, 8'hA0, 1'b1, 1'b0);
    end_load();
  endtask

  task automatic t_timeout();
    send("R10", 16'h1555, 8'hAA, 1'b0, 1'b0);
    send("R10", 16'h0AAA, 8'h55, 1'b0, 1'b0);
    end_load();
    send("R10", 16'h1555, 8'hA0, 1'b1, 1'b0);
    end_load();
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_addr = 16'h0010; in_data = 8'h11;
    @(negedge clk);
    in_addr = 16'h0020; in_data = 8'h22;
    chk("R11", "first beat", int'(out_data), 8'h11);
    chk("R11", "in_ready stalled", int'(in_ready), 0);
    @(negedge clk);
    chk("R11", "held beat", int'(out_data), 8'h11);
    chk("R11", "held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "second beat", int'(out_data), 8'h22);
    chk("R11", "second addr", int'(out_addr), 16'h0020);
    @(negedge clk);
    chk("R11", "drained", int'(out_valid), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    por_n = 1'b1; rst_n = 1'b1;
    t_reset();
    t_plain();
    t_lock();
    t_abort_prot();
    t_warm();
    t_unlock();
    t_abort_unprot();
    t_timeout();
    t_stall();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule